// File: doc/BRIEF.md
# Configuration Boot and Reset Sequencer

This block brings a programmable clock generator out of reset. When power-on reset is released, it waits a fixed settling interval. It then reads a default configuration image from a non-volatile memory, one word per address in ascending order, and writes it into a staging register file. In a single commit cycle it copies the staging file into the committed configuration that drives the rest of the chip. During this whole sequence the host register port refuses every access and all output clock enables are held low.

Two classes of reset are supported. A hard reset repeats the full power-up sequence. It clears the staging and committed registers, returns the host port to its refusing state, and reloads the image from non-volatile memory. A hard reset comes from an external pin, which passes through a two-flop synchronizer, or from a self-clearing control bit. A soft reset does not touch non-volatile memory. It only commits the words the host has written into the staging file. A soft reset comes from a request input or from a control bit.

The non-volatile memory has a synchronous read port with a fixed latency. The host port is a simple word-wide read/write port, so the serial protocol in front of it sits elsewhere.

Top module: `cfgBootSeq`

## Requirements
- R1: After power-on reset is released, the sequencer waits POR_CYC cycles. It then reads non-volatile addresses 0 to N_WORDS-1 in ascending order, asserting nvmRdEn for one cycle per address. The data for a read is taken NVM_LAT cycles after that read's nvmRdEn cycle. The next read is issued only after the previous data has been taken, so nvmRdEn is never high in two consecutive cycles.
- R2: After the last word is taken, one commit cycle follows and then initDone goes to 1. At that point cfgActive holds the image, with word i in bits [i*WORD_W +: WORD_W].
- R3: While initDone is 0, hostAck is 0 and hostRdData is 0, and a host write has no effect. A word written during the load reads back afterwards as the non-volatile value.
- R4: clkOutEn equals the low N_OUT bits of committed word 0 while initDone is 1, and is all zeros otherwise.
- R5: A host write to an address a < N_WORDS changes staging word a, which reads back through the host port at once. cfgActive stays unchanged until a commit.
- R6: A soft reset in the ready state commits the staging file to cfgActive. initDone drops for exactly one cycle and no non-volatile read is issued. A soft reset is raised by a one-cycle pulse on softRstReq, or by writing a word with bit 1 set to the control address N_WORDS.
- R7: Writing a word with bit 0 set to the control address starts a hard reset. Two cycles after the write, initDone is 0 and cfgActive is all zeros. The full sequence of R1 and R2 then repeats and restores the image. The control bit clears itself when the load starts.
- R8: hardRstPin is synchronized by two flops. When it is high in cycle k, the host port refuses access from cycle k+2 and the sequencer is back in its settling interval from cycle k+3. The sequencer stays there while the pin stays high.
- R9: A soft request that arrives during the load or the commit is held. It produces one additional commit after initDone first rises. A soft request that arrives during the settling interval is dropped.
- R10: A host read of the control address returns a status word: bit 0 is 1 (ready), bit 1 is the pending hard-reset bit, bit 2 is the pending soft request, and the other bits are 0.
- R11: A host write that is accepted in the cycle a pending soft request is taken is included in that commit. A host access in any cycle where the synchronized pin is high is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| hardRstPin | input | 1 | External hard-reset request, asynchronous, active high |
| softRstReq | input | 1 | Soft-reset request pulse |
| nvmRdEn | output | 1 | Non-volatile memory read strobe |
| nvmAddr | output | NAW | Non-volatile memory read address |
| nvmRdData | input | WORD_W | Non-volatile read data, valid NVM_LAT cycles after the strobe |
| hostWrEn | input | 1 | Host write request |
| hostRdEn | input | 1 | Host read request |
| hostAddr | input | HAW | Host word address; N_WORDS is the control/status address |
| hostWrData | input | WORD_W | Host write data |
| hostAck | output | 1 | Host access accepted this cycle |
| hostRdData | output | WORD_W | Host read data, zero when the access is refused |
| initDone | output | 1 | Sequencer is in the ready state |
| clkOutEn | output | N_OUT | Output clock enables |
| cfgActive | output | N_WORDS*WORD_W | Committed configuration, flattened |

## Verification
Three pairs of functions can fall in the same cycle, and each pair is provoked on purpose. First, a host write is accepted in the cycle a pending soft request is taken; the bench then checks that the written word appears in cfgActive after the single commit. Second, the synchronized reset pin goes high in the same cycle as a host write; the bench checks that the write gets no acknowledge and is lost after the reload. Third, a soft request arrives while the load is still running; the bench counts the cycles in which initDone is low after the first rise and expects exactly one extra commit. A behavioural model tracks every port on every cycle, so any difference in the cycle of a transition shows up as a mismatch.

// File: rtl/cfgBootPkg.sv
package cfgBootPkg;

  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_LOAD  = 2'd1,
    ST_APPLY = 2'd2,
    ST_READY = 2'd3
  } seqState_t;

  // strobes from the control FSM into the register datapath
  typedef struct packed {
    logic clearAll;
    logic issueRd;
    logic capture;
    logic commit;
    logic hostWr;
  } seqStrobe_t;

endpackage

// File: rtl/cfgBootCtrl.sv
module cfgBootCtrl
  import cfgBootPkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int POR_CYC = 4,
  parameter int HAW     = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hardRstPin,
  input  logic           softRstReq,
  input  logic           hostWrEn,
  input  logic [HAW-1:0] hostAddr,
  input  logic [1:0]     ctlBits,
  input  logic           wordDone,
  input  logic           lastWord,
  input  logic           inFlight,
  output seqStrobe_t     strobe,
  output logic           hostReady,
  output logic           initDone,
  output logic           hardBit,
  output logic           softPend
);

  localparam int PCW = $clog2(POR_CYC + 1);

  seqState_t       state;
  logic [PCW-1:0]  porCnt;
  logic            pinMeta;
  logic            pinSync;
  logic            ctlWr;
  logic            softNow;
  logic            takeSoft;
  logic            porDone;

  // two-flop synchronizer for the external hard reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinMeta <= 1'b0;
      pinSync <= 1'b0;
    end else begin
      pinMeta <= hardRstPin;
      pinSync <= pinMeta;
    end
  end

  assign hostReady = (state == ST_READY) && !pinSync && !hardBit;
  assign ctlWr     = hostReady && hostWrEn && (hostAddr == HAW'(N_WORDS));
  assign softNow   = softRstReq || (ctlWr && ctlBits[1]);
  assign takeSoft  = (state == ST_READY) && !hardBit && softPend && !pinSync;
  assign porDone   = (state == ST_POR) && (porCnt == PCW'(POR_CYC - 1));
  assign initDone  = (state == ST_READY);

  always_comb begin
    strobe.clearAll = pinSync || ((state == ST_READY) && hardBit);
    strobe.issueRd  = (state == ST_LOAD) && !inFlight && !pinSync;
    strobe.capture  = (state == ST_LOAD) && wordDone && !pinSync;
    strobe.commit   = (state == ST_APPLY) && !pinSync;
    strobe.hostWr   = hostReady && hostWrEn && (hostAddr < HAW'(N_WORDS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_POR;
      porCnt <= '0;
    end else if (strobe.clearAll) begin
      state  <= ST_POR;
      porCnt <= '0;
    end else begin
      unique case (state)
        ST_POR: begin
          if (porDone) begin
            state  <= ST_LOAD;
            porCnt <= '0;
          end else begin
            porCnt <= porCnt + 1'b1;
          end
        end
        ST_LOAD:  if (wordDone && lastWord) state <= ST_APPLY;
        ST_APPLY: state <= ST_READY;
        ST_READY: if (takeSoft) state <= ST_APPLY;
        default:  state <= ST_POR;
      endcase
    end
  end

  // self-clearing hard-reset control bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    hardBit <= 1'b0;
    else if (ctlWr && ctlBits[0]) hardBit <= 1'b1;
    else if (porDone)             hardBit <= 1'b0;
  end

  // soft request latch: dropped in the settling interval, held elsewhere
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 softPend <= 1'b0;
    else if (strobe.clearAll)  softPend <= 1'b0;
    else if (state == ST_POR)  softPend <= 1'b0;
    else                       softPend <= (softPend && !takeSoft) || softNow;
  end

endmodule

// File: rtl/cfgBootData.sv
module cfgBootData
  import cfgBootPkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 8,
  parameter int NVM_LAT = 2,
  parameter int HAW     = 4,
  parameter int NAW     = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strobe,
  input  logic [HAW-1:0]              hostAddr,
  input  logic [WORD_W-1:0]           hostWrData,
  input  logic                        hostRead,
  input  logic [2:0]                  statusBits,
  input  logic [WORD_W-1:0]           nvmRdData,
  output logic [NAW-1:0]              nvmAddr,
  output logic                        wordDone,
  output logic                        lastWord,
  output logic                        inFlight,
  output logic [N_WORDS*WORD_W-1:0]   cfgActive,
  output logic [WORD_W-1:0]           hostRdData
);

  logic [NVM_LAT-1:0] rdPipe;
  logic [NAW-1:0]     loadAddr;
  logic [WORD_W-1:0]  stageMem [N_WORDS];
  logic [WORD_W-1:0]  rdMux;

  // read-valid pipeline matching the memory latency
  for (genvar s = 0; s < NVM_LAT; s++) begin : gPipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                rdPipe[s] <= 1'b0;
      else if (strobe.clearAll) rdPipe[s] <= 1'b0;
      else if (s == 0)          rdPipe[s] <= strobe.issueRd;
      else                      rdPipe[s] <= rdPipe[(s == 0) ? 0 : s-1];
    end
  end

  assign inFlight = |rdPipe;
  assign wordDone = rdPipe[NVM_LAT-1];
  assign lastWord = (loadAddr == NAW'(N_WORDS - 1));
  assign nvmAddr  = loadAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                loadAddr <= '0;
    else if (strobe.clearAll) loadAddr <= '0;
    else if (strobe.capture)  loadAddr <= lastWord ? '0 : loadAddr + 1'b1;
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stageMem[g] <= '0;
      else if (strobe.clearAll)
        stageMem[g] <= '0;
      else if (strobe.capture && (loadAddr == NAW'(g)))
        stageMem[g] <= nvmRdData;
      else if (strobe.hostWr && (hostAddr == HAW'(g)))
        stageMem[g] <= hostWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cfgActive[g*WORD_W +: WORD_W] <= '0;
      else if (strobe.clearAll) cfgActive[g*WORD_W +: WORD_W] <= '0;
      else if (strobe.commit)   cfgActive[g*WORD_W +: WORD_W] <= stageMem[g];
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      if (hostAddr == HAW'(i)) rdMux = stageMem[i];
    end
    if (hostAddr == HAW'(N_WORDS)) rdMux = WORD_W'(statusBits);
  end

  assign hostRdData = hostRead ? rdMux : '0;

endmodule

// File: rtl/cfgBootSeq.sv
module cfgBootSeq
  import cfgBootPkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 8,
  parameter int N_OUT   = 4,
  parameter int NVM_LAT = 2,
  parameter int POR_CYC = 4,
  localparam int HAW    = $clog2(N_WORDS + 1),
  localparam int NAW    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hardRstPin,
  input  logic                      softRstReq,
  output logic                      nvmRdEn,
  output logic [NAW-1:0]            nvmAddr,
  input  logic [WORD_W-1:0]         nvmRdData,
  input  logic                      hostWrEn,
  input  logic                      hostRdEn,
  input  logic [HAW-1:0]            hostAddr,
  input  logic [WORD_W-1:0]         hostWrData,
  output logic                      hostAck,
  output logic [WORD_W-1:0]         hostRdData,
  output logic                      initDone,
  output logic [N_OUT-1:0]          clkOutEn,
  output logic [N_WORDS*WORD_W-1:0] cfgActive
);

  seqStrobe_t strobe;
  logic       hostReady;
  logic       hardBit;
  logic       softPend;
  logic       wordDone;
  logic       lastWord;
  logic       inFlight;

  cfgBootCtrl #(
    .N_WORDS(N_WORDS), .POR_CYC(POR_CYC), .HAW(HAW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hardRstPin(hardRstPin), .softRstReq(softRstReq),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .ctlBits(hostWrData[1:0]),
    .wordDone(wordDone), .lastWord(lastWord), .inFlight(inFlight),
    .strobe(strobe), .hostReady(hostReady), .initDone(initDone),
    .hardBit(hardBit), .softPend(softPend)
  );

  cfgBootData #(
    .N_WORDS(N_WORDS), .WORD_W(WORD_W), .NVM_LAT(NVM_LAT), .HAW(HAW), .NAW(NAW)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRead(hostReady && hostRdEn),
    .statusBits({softPend, hardBit, initDone}), .nvmRdData(nvmRdData),
    .nvmAddr(nvmAddr), .wordDone(wordDone), .lastWord(lastWord),
    .inFlight(inFlight), .cfgActive(cfgActive), .hostRdData(hostRdData)
  );

  assign nvmRdEn  = strobe.issueRd;
  assign hostAck  = hostReady && (hostWrEn || hostRdEn);
  assign clkOutEn = initDone ? cfgActive[N_OUT-1:0] : '0;

endmodule

// File: rtl/cfgBootChk.sv
module cfgBootChk #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 8,
  parameter int N_OUT   = 4,
  parameter int HAW     = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      hardRstPin,
  input logic                      hostWrEn,
  input logic [HAW-1:0]            hostAddr,
  input logic [WORD_W-1:0]         hostWrData,
  input logic                      hostAck,
  input logic                      initDone,
  input logic                      nvmRdEn,
  input logic [N_OUT-1:0]          clkOutEn,
  input logic [N_WORDS*WORD_W-1:0] cfgActive
);

  // R1: one read outstanding at a time, so strobes never come back to back
  p_rd_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    nvmRdEn |=> !nvmRdEn);

  // R3: host port refuses every access before ready
  p_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !hostAck);

  // R4: clocks stay gated until ready
  p_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (clkOutEn == '0));

  // R5: committed image only moves through a commit or a hard reset
  p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && $past(initDone)) |-> $stable(cfgActive));

  // R6: no memory traffic while ready
  p_no_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !nvmRdEn);

  // R7: control-bit hard reset clears the committed image two cycles later
  p_hard_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck && hostWrEn && (hostAddr == HAW'(N_WORDS)) && hostWrData[0])
      |-> ##2 (!initDone && (cfgActive == '0)));

  // R8: synchronized pin blocks host access two cycles after it is seen
  p_pin_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(hardRstPin, 2) |-> !hostAck);

endmodule

bind cfgBootSeq cfgBootChk #(
  .N_WORDS(N_WORDS), .WORD_W(WORD_W), .N_OUT(N_OUT), .HAW(HAW)
) uChk (
  .clk(clk), .rstN(rstN), .hardRstPin(hardRstPin), .hostWrEn(hostWrEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .hostAck(hostAck),
  .initDone(initDone), .nvmRdEn(nvmRdEn), .clkOutEn(clkOutEn),
  .cfgActive(cfgActive)
);

// File: tb/sim_cfgBootSeq.sv
module sim_cfgBootSeq;

  localparam int NW = 8;
  localparam int WW = 8;
  localparam int NO = 4;
  localparam int PORC = 4;
  localparam int CTL = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hardRstPin = 1'b0;
  logic        softRstReq = 1'b0;
  logic        nvmRdEn;
  logic [2:0]  nvmAddr;
  logic [7:0]  nvmRdData;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        hostAck;
  logic [7:0]  hostRdData;
  logic        initDone;
  logic [3:0]  clkOutEn;
  logic [63:0] cfgActive;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfgBootSeq u0 (
    .clk(clk), .rstN(rstN), .hardRstPin(hardRstPin), .softRstReq(softRstReq),
    .nvmRdEn(nvmRdEn), .nvmAddr(nvmAddr), .nvmRdData(nvmRdData),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostAck(hostAck), .hostRdData(hostRdData),
    .initDone(initDone), .clkOutEn(clkOutEn), .cfgActive(cfgActive)
  );

  function automatic logic [7:0] nvmWord(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [63:0] image();
    logic [63:0] v = '0;
    for (int i = 0; i < NW; i++) v[i*8 +: 8] = nvmWord(i);
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // non-volatile memory: two-cycle synchronous read
  logic [7:0] nv1 = '0, nv2 = '0;
  always @(posedge clk) begin
    nv1 <= nvmRdEn ? nvmWord(int'(nvmAddr)) : 8'h00;
    nv2 <= nv1;
  end
  assign nvmRdData = nv2;

  // behavioural reference model
  int mState, mPor, mAddr, mAge;
  bit mHard, mPend, ms1, ms2;
  logic [7:0] mStage [NW];
  logic [7:0] mActive [NW];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPor = 0; mAddr = 0; mAge = -1;
      mHard = 0; mPend = 0; ms1 = 0; ms2 = 0;
      for (int i = 0; i < NW; i++) begin mStage[i] = '0; mActive[i] = '0; end
    end else begin
      bit rdy, ctl, stg, clr, req, take, wd, iss;
      rdy  = (mState == 3) && !ms2 && !mHard;
      ctl  = rdy && hostWrEn && (hostAddr == CTL);
      stg  = rdy && hostWrEn && (hostAddr < CTL);
      clr  = ms2 || ((mState == 3) && mHard);
      req  = softRstReq || (ctl && hostWrData[1]);
      take = (mState == 3) && !mHard && mPend && !ms2;
      wd   = (mState == 1) && (mAge == 1) && !ms2;
      iss  = (mState == 1) && (mAge < 0) && !ms2;
      if (stg) mStage[hostAddr] = hostWrData;
      if (clr) begin
        for (int i = 0; i < NW; i++) begin mStage[i] = '0; mActive[i] = '0; end
        mAddr = 0; mAge = -1; mPend = 0; mState = 0; mPor = 0;
      end else begin
        if (ctl && hostWrData[0]) mHard = 1;
        if (mState == 0) mPend = 0;
        else mPend = (mPend && !take) || req;
        if (iss) mAge = 0;
        else if (mAge >= 0) mAge = (mAge == 1) ? -1 : mAge + 1;
        case (mState)
          0: if (mPor == PORC - 1) begin mState = 1; mPor = 0; mHard = 0; mAddr = 0; end
             else mPor++;
          1: if (wd) begin
               mStage[mAddr] = nvmWord(mAddr);
               if (mAddr == NW - 1) begin mState = 2; mAddr = 0; end
               else mAddr++;
             end
          2: begin for (int i = 0; i < NW; i++) mActive[i] = mStage[i]; mState = 3; end
          default: if (take) mState = 2;
        endcase
      end
      ms2 = ms1;
      ms1 = hardRstPin;
    end
  end

  // compare every port against the model on every cycle
  always @(posedge clk) begin
    #2;
    if (!done) begin
      bit eInit, eRdEn, eRdy;
      logic [63:0] eAct;
      logic [7:0] eRd;
      eInit = (mState == 3);
      eRdEn = (mState == 1) && (mAge < 0) && !ms2;
      eRdy  = (mState == 3) && !ms2 && !mHard;
      for (int i = 0; i < NW; i++) eAct[i*8 +: 8] = mActive[i];
      eRd = 8'h00;
      if (eRdy && hostRdEn) begin
        if (hostAddr < CTL) eRd = mStage[hostAddr];
        else if (hostAddr == CTL) eRd = {5'b0, mPend, mHard, 1'b1};
      end
      chk("R2 initDone (model)", 64'(initDone), 64'(eInit));
      chk("R2 cfgActive (model)", cfgActive, eAct);
      chk("R4 clkOutEn (model)", 64'(clkOutEn), eInit ? 64'(mActive[0][3:0]) : 64'd0);
      chk("R1 nvmRdEn (model)", 64'(nvmRdEn), 64'(eRdEn));
      if (eRdEn) chk("R1 nvmAddr (model)", 64'(nvmAddr), 64'(mAddr));
      chk("R3 hostAck (model)", 64'(hostAck), 64'(eRdy && (hostWrEn || hostRdEn)));
      chk("R10 hostRdData (model)", 64'(hostRdData), 64'(eRd));
    end
  end

  task automatic hostWrite(int a, logic [7:0] d, output logic ack);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 4'(a); hostWrData = d;
    #1 ack = hostAck;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(int a, output logic [7:0] d, output logic ack);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = 4'(a);
    #1 d = hostRdData; ack = hostAck;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic softPulse();
    @(negedge clk); softRstReq = 1'b1;
    @(negedge clk); softRstReq = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (initDone) return;
    end
  endtask

  task automatic lowCount(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (!initDone) c++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    int lows;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset initDone", 64'(initDone), 0);
    chk("R1 reset nvmRdEn", 64'(nvmRdEn), 0);
    chk("R1 reset cfgActive", cfgActive, 0);

    // release; soft request inside the settling interval must be dropped (R9)
    @(negedge clk); rstN = 1'b1; softRstReq = 1'b1;
    @(negedge clk); softRstReq = 1'b0;
    repeat (8) @(negedge clk);
    hostWrite(2, 8'hFF, ack);
    chk("R3 write refused during load", 64'(ack), 0);
    hostRead(2, rd, ack);
    chk("R3 read data zero during load", 64'(rd), 0);
    waitReady();
    chk("R2 image committed", cfgActive, image());
    chk("R4 clocks follow word 0", 64'(clkOutEn), 64'(nvmWord(0) & 8'h0F));
    lowCount(5, lows);
    chk("R9 request in settling dropped", 64'(lows), 0);
    hostRead(2, rd, ack);
    chk("R3 refused write had no effect", 64'(rd), 64'(nvmWord(2)));
    hostRead(CTL, rd, ack);
    chk("R10 status idle", 64'(rd), 64'h01);

    // R5: staging changes without touching the committed image
    hostWrite(5, 8'h33, ack);
    hostWrite(0, 8'h0A, ack);
    #1 chk("R5 committed unchanged", cfgActive, image());
    hostRead(5, rd, ack);
    chk("R5 staging readback", 64'(rd), 64'h33);

    // R6: soft reset by pulse
    softPulse();
    lowCount(4, lows);
    chk("R6 one low cycle (pulse)", 64'(lows), 1);
    chk("R6 word5 committed", 64'(cfgActive[5*8 +: 8]), 64'h33);
    chk("R4 clocks after commit", 64'(clkOutEn), 64'hA);

    // R6: soft reset by control bit
    hostWrite(3, 8'hC3, ack);
    hostWrite(CTL, 8'h02, ack);
    lowCount(4, lows);
    chk("R6 one low cycle (control)", 64'(lows), 1);
    chk("R6 word3 committed", 64'(cfgActive[3*8 +: 8]), 64'hC3);

    // R11: write accepted in the cycle the pending request is taken
    @(negedge clk); softRstReq = 1'b1;
    @(negedge clk); softRstReq = 1'b0;
    hostWrEn = 1'b1; hostAddr = 4'd1; hostWrData = 8'h77;
    #1 chk("R11 write accepted in take cycle", 64'(hostAck), 1);
    @(negedge clk); hostWrEn = 1'b0;
    lowCount(4, lows);
    chk("R11 write joined the commit", 64'(cfgActive[1*8 +: 8]), 64'h77);

    // R10: pending soft bit visible in the take cycle
    @(negedge clk); softRstReq = 1'b1;
    @(negedge clk); softRstReq = 1'b0;
    hostRdEn = 1'b1; hostAddr = 4'(CTL);
    #1 chk("R10 status with pending soft", 64'(hostRdData), 64'h05);
    @(negedge clk); hostRdEn = 1'b0;
    lowCount(4, lows);

    // R7: hard reset through the control bit, R9 soft request during the load
    hostWrite(CTL, 8'h01, ack);
    @(negedge clk); #1;
    chk("R7 not ready after hard bit", 64'(initDone), 0);
    chk("R7 committed image cleared", cfgActive, 0);
    repeat (10) @(negedge clk);
    softRstReq = 1'b1;
    @(negedge clk); softRstReq = 1'b0;
    waitReady();
    chk("R7 image reloaded", cfgActive, image());
    lowCount(4, lows);
    chk("R9 held request gives one more commit", 64'(lows), 1);

    // R8 and R11: pin reset collides with a host write
    @(negedge clk); hardRstPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = 4'd3; hostWrData = 8'h55;
    #1 chk("R11 write refused with pin synced", 64'(hostAck), 0);
    @(negedge clk); hostWrEn = 1'b0;
    #1 chk("R8 sequencer restarted", 64'(initDone), 0);
    repeat (4) @(negedge clk);
    #1 chk("R8 held while pin high", 64'(initDone), 0);
    hardRstPin = 1'b0;
    waitReady();
    hostRead(3, rd, ack);
    chk("R8 reload restored word 3", 64'(rd), 64'(nvmWord(3)));
    chk("R8 image after pin reset", cfgActive, image());

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule